// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block carries 18-bit words in one direction between two unrelated clock domains. A producer on `wr_clk` pushes words into a dual-port array. A consumer on `rd_clk` pops them into a registered output, `rd_data`. Each side has an active-low enable and a direction control, so it can share its strobes with a bidirectional port controller. The write pointer and the read pointer each cross to the other domain as Gray code through a two-flop synchroniser.

Four active-low flags report the fill level. Each flag comes from the domain of the side that acts on it.

- **Read side.** The read domain holds a three-state level machine whose states are `RS_EMPTY`, `RS_LOW` and `RS_PLENTY`. It drives `empty_n` and `aempty_n`.
- **Write side.** The write domain holds the mirror machine, with states `WS_OPEN`, `WS_HIGH` and `WS_FULL`. It drives `full_n` and `afull_n`.
- **Transitions.** A machine has no fixed arcs. On every edge of its own clock it moves to the state chosen by the occupancy it sees, and that occupancy already includes this edge's push or pop.
  - Read side: the count after the edge is zero → `RS_EMPTY`; it is between 1 and the low threshold → `RS_LOW`; it is above the threshold → `RS_PLENTY`.
  - Write side: the count is the depth → `WS_FULL`; the count plus the high threshold reaches the depth → `WS_HIGH`; otherwise → `WS_OPEN`.

As a result, a flag driven by the local side's own action asserts on that same edge. A flag released by the far side's action clears a few local cycles later.

The two thresholds sit in offset registers that a controller loads on `wr_clk`. Both reset to 8.

Top module: `pflag_fifo`

## Requirements
- R1: While `rst_n` is low, and until the first operation after reset, `empty_n`=0, `aempty_n`=0, `full_n`=1 and `afull_n`=1. Both offsets reset to 8.
- R2: A word is stored on a rising `wr_clk` edge when `wr_en_n`=0, `wr_dir`=0 and `full_n`=1. With `wr_dir`=1, nothing is stored. Stored words are read back in the order they were written.
- R3: A push attempted while `full_n`=0 is dropped, and the stored contents do not change.
- R4: On a rising `rd_clk` edge with `rd_en_n`=0, `rd_dir`=1 and `empty_n`=1, the oldest word is loaded into `rd_data`. In every other case, `rd_data` holds its value and nothing is removed.
- R5: `empty_n` is low exactly when the read side counts zero words. A pop attempted while `empty_n`=0 is dropped.
- R6: `aempty_n` is low while the count is at most n, where n is the almost-empty offset. It is high above n.
- R7: `afull_n` is low while the count is at least D−m, where m is the almost-full offset and D is the depth. It is high below D−m.
- R8: `full_n` is low exactly at D words, and the count never exceeds D.
- R9: On a rising `wr_clk` edge with `cfg_we`=1, `cfg_data[8:0]` is loaded into the almost-empty offset when `cfg_sel`=0, or into the almost-full offset when `cfg_sel`=1. Without `cfg_we`, both offsets hold their values. With D=256, bit 8 must be written as 0. The almost-empty offset is consumed on `rd_clk`, so it is changed only while the read side is idle.
- R10: `empty_n`/`aempty_n` come from `rd_clk` registers, and `full_n`/`afull_n` come from `wr_clk` registers.
  - A flag that the local side's own push or pop asserts is correct right after that edge.
  - A flag released by the other side is correct within four of its own clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| rd_clk | input | 1 | Consumer clock |
| rst_n | input | 1 | Asynchronous active-low reset of both domains |
| wr_en_n | input | 1 | Active-low push enable |
| wr_dir | input | 1 | Producer direction, 0 selects push |
| wr_data | input | 18 | Word to push |
| cfg_we | input | 1 | Offset load strobe (wr_clk) |
| cfg_sel | input | 1 | 0 almost-empty offset, 1 almost-full offset |
| cfg_data | input | 9 | Offset value |
| rd_en_n | input | 1 | Active-low pop enable |
| rd_dir | input | 1 | Consumer direction, 1 selects pop |
| rd_data | output | 18 | Registered output word |
| empty_n | output | 1 | Low when empty (rd_clk) |
| aempty_n | output | 1 | Low at or below the almost-empty offset (rd_clk) |
| afull_n | output | 1 | Low at or above depth minus the almost-full offset (wr_clk) |
| full_n | output | 1 | Low when full (wr_clk) |

## Verification
The bench builds the block with a depth of 16 and 9-bit offsets. At that depth, every occupancy from 0 to full can be stepped through one word at a time. The sweep is repeated for four offset pairs: the reset default, zero, a middle pair, and the extremes 15 and 1. Every flag is then compared against an arithmetic count model at every level, both right after the local edge and after the crossing has settled. The same small depth puts overflow, underflow, output hold and a long back-pressured stream under the unrelated 5 ns and 7 ns clocks within a few thousand cycles.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
    typedef enum logic [1:0] {
        RS_EMPTY  = 2'd0,
        RS_LOW    = 2'd1,
        RS_PLENTY = 2'd2
    } rd_level_e;

    typedef enum logic [1:0] {
        WS_OPEN = 2'd0,
        WS_HIGH = 2'd1,
        WS_FULL = 2'd2
    } wr_level_e;
endpackage

// File: rtl/pflag_gray_sync.sv
module pflag_gray_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pflag_ram.sv
module pflag_ram #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (re) q <= mem[raddr];
    end

    // R4: output register only moves on an accepted pop
    p_out_hold_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !re |=> $stable(q));
endmodule

// File: rtl/pflag_wr_ctrl.sv
module pflag_wr_ctrl
    import pflag_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int PW    = 9,
    parameter int OFS_W = 9
) (
    input  logic             wr_clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [PW-1:0]    rgray_s,
    input  logic [OFS_W-1:0] af_ofs,
    output logic             wr_fire,
    output logic [AW-1:0]    waddr,
    output logic [PW-1:0]    wgray,
    output logic             full_n,
    output logic             afull_n
);
    localparam int SW = ((PW > OFS_W) ? PW : OFS_W) + 1;

    wr_level_e     lvl, lvl_nx;
    logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt_nx;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    assign wr_fire = wr_req && (lvl != WS_FULL);
    assign wbin_nx = wbin + PW'(wr_fire);
    assign cnt_nx  = wbin_nx - rbin_s;
    assign waddr   = wbin[AW-1:0];

    always_comb begin
        if (cnt_nx == PW'(DEPTH))
            lvl_nx = WS_FULL;
        else if (SW'(cnt_nx) + SW'(af_ofs) >= SW'(DEPTH))
            lvl_nx = WS_HIGH;
        else
            lvl_nx = WS_OPEN;
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl   <= WS_OPEN;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            lvl   <= lvl_nx;
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    always_comb begin
        unique case (lvl)
            WS_OPEN: begin full_n = 1'b1; afull_n = 1'b1; end
            WS_HIGH: begin full_n = 1'b1; afull_n = 1'b0; end
            WS_FULL: begin full_n = 1'b0; afull_n = 1'b0; end
            default: begin full_n = 1'b0; afull_n = 1'b0; end
        endcase
    end

    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && wr_req) |=> $stable(wbin));

    p_count_bound_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        cnt_nx <= PW'(DEPTH));
endmodule

// File: rtl/pflag_rd_ctrl.sv
module pflag_rd_ctrl
    import pflag_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int PW    = 9,
    parameter int OFS_W = 9
) (
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [PW-1:0]    wgray_s,
    input  logic [OFS_W-1:0] ae_ofs,
    output logic             rd_fire,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rgray,
    output logic             empty_n,
    output logic             aempty_n
);
    localparam int SW = ((PW > OFS_W) ? PW : OFS_W) + 1;

    rd_level_e     lvl, lvl_nx;
    logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_nx;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign rd_fire = rd_req && (lvl != RS_EMPTY);
    assign rbin_nx = rbin + PW'(rd_fire);
    assign cnt_nx  = wbin_s - rbin_nx;
    assign raddr   = rbin[AW-1:0];

    always_comb begin
        if (cnt_nx == '0)
            lvl_nx = RS_EMPTY;
        else if (SW'(cnt_nx) <= SW'(ae_ofs))
            lvl_nx = RS_LOW;
        else
            lvl_nx = RS_PLENTY;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl   <= RS_EMPTY;
            rbin  <= '0;
            rgray <= '0;
        end else begin
            lvl   <= lvl_nx;
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    always_comb begin
        unique case (lvl)
            RS_EMPTY:  begin empty_n = 1'b0; aempty_n = 1'b0; end
            RS_LOW:    begin empty_n = 1'b1; aempty_n = 1'b0; end
            RS_PLENTY: begin empty_n = 1'b1; aempty_n = 1'b1; end
            default:   begin empty_n = 1'b0; aempty_n = 1'b0; end
        endcase
    end

    p_no_underflow_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n && rd_req) |=> $stable(rbin));

    p_no_wrap_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        cnt_nx <= PW'(DEPTH));
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo #(
    parameter int WIDTH       = 18,
    parameter int DEPTH       = 256,
    parameter int OFS_W       = 9,
    parameter int OFS_DEFAULT = 8
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             wr_en_n,
    input  logic             wr_dir,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [OFS_W-1:0] cfg_data,
    input  logic             rd_en_n,
    input  logic             rd_dir,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty_n,
    output logic             aempty_n,
    output logic             afull_n,
    output logic             full_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [OFS_W-1:0] ae_ofs, af_ofs;
    logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0]    waddr, raddr;
    logic             wr_fire, rd_fire;

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_ofs <= OFS_W'(OFS_DEFAULT);
            af_ofs <= OFS_W'(OFS_DEFAULT);
        end else if (cfg_we) begin
            if (cfg_sel) af_ofs <= cfg_data;
            else         ae_ofs <= cfg_data;
        end
    end

    p_ofs_hold_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(ae_ofs) && $stable(af_ofs)));

    pflag_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .OFS_W(OFS_W)) u_wr (
        .wr_clk (wr_clk), .rst_n(rst_n), .wr_req(!wr_en_n && !wr_dir),
        .rgray_s(rgray_s), .af_ofs(af_ofs), .wr_fire(wr_fire),
        .waddr  (waddr), .wgray(wgray), .full_n(full_n), .afull_n(afull_n)
    );

    pflag_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .OFS_W(OFS_W)) u_rd (
        .rd_clk (rd_clk), .rst_n(rst_n), .rd_req(!rd_en_n && rd_dir),
        .wgray_s(wgray_s), .ae_ofs(ae_ofs), .rd_fire(rd_fire),
        .raddr  (raddr), .rgray(rgray), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    pflag_gray_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    pflag_gray_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    pflag_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .wr_clk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .re(rd_fire), .raddr(raddr),
        .q(rd_data)
    );
endmodule

// File: tb/pflag_fifo_bench.sv
`timescale 1ns/100ps
module pflag_fifo_bench;
    localparam int W = 18;
    localparam int D = 16;
    localparam int OW = 9;

    logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic          wr_en_n = 1'b1, wr_dir = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
    logic          rd_en_n = 1'b1, rd_dir = 1'b1;
    logic [W-1:0]  wr_data = '0;
    logic [OW-1:0] cfg_data = '0;
    logic [W-1:0]  rd_data;
    logic          empty_n, aempty_n, afull_n, full_n;

    int n_chk = 0, n_fail = 0;
    int cnt = 0, n_off = 8, m_off = 8;
    bit done = 0;

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    pflag_fifo #(.WIDTH(W), .DEPTH(D), .OFS_W(OW), .OFS_DEFAULT(8)) u_pflag_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en_n(wr_en_n), .wr_dir(wr_dir), .wr_data(wr_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .rd_en_n(rd_en_n), .rd_dir(rd_dir), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n), .afull_n(afull_n), .full_n(full_n)
    );

    function automatic logic [W-1:0] pat(input int r, input int i);
        return W'((r * 4099 + i * 37) ^ 18'h15A5A);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic chk_rd_flags(input string tag);
        chk(empty_n == (cnt != 0), {tag, " R5 empty_n"}, int'(empty_n), int'(cnt != 0));
        chk(aempty_n == (cnt > n_off), {tag, " R6 aempty_n"}, int'(aempty_n), int'(cnt > n_off));
    endtask

    task automatic chk_wr_flags(input string tag);
        chk(full_n == (cnt != D), {tag, " R8 full_n"}, int'(full_n), int'(cnt != D));
        chk(afull_n == (cnt < D - m_off), {tag, " R7 afull_n"}, int'(afull_n), int'(cnt < D - m_off));
    endtask

    task automatic settle();
        repeat (4) @(posedge rd_clk);
        repeat (4) @(posedge wr_clk);
        #1;
    endtask

    task automatic push(input logic [W-1:0] d);
        @(negedge wr_clk);
        wr_en_n = 1'b0; wr_dir = 1'b0; wr_data = d;
        @(posedge wr_clk);
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic pop();
        @(negedge rd_clk);
        rd_en_n = 1'b0; rd_dir = 1'b1;
        @(posedge rd_clk);
        @(negedge rd_clk);
        rd_en_n = 1'b1;
    endtask

    task automatic load_ofs(input bit sel, input int v);
        @(negedge wr_clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = OW'(v);
        @(negedge wr_clk);
        cfg_we = 1'b0;
    endtask

    task automatic sweep(input int r, input int n, input int m, input bit load);
        if (load) begin
            load_ofs(1'b0, n);
            load_ofs(1'b1, m);
        end
        n_off = n; m_off = m;
        settle();
        chk_rd_flags("R9 after load");
        chk_wr_flags("R9 after load");
        for (int i = 0; i < D; i++) begin
            push(pat(r, i));
            cnt++;
            chk_wr_flags("R10 own-side after push");
            settle();
            chk_rd_flags("R10 crossed after push");
        end
        push(18'h3FFFF);
        chk(full_n == 1'b0, "R3 full stays low on dropped push", int'(full_n), 0);
        settle();
        for (int i = 0; i < D; i++) begin
            pop();
            chk(rd_data == pat(r, i), "R2 R4 order", int'(rd_data), int'(pat(r, i)));
            cnt--;
            chk_rd_flags("R10 own-side after pop");
            settle();
            chk_wr_flags("R10 crossed after pop");
        end
        pop();
        chk(rd_data == pat(r, D - 1), "R5 pop at empty keeps rd_data", int'(rd_data), int'(pat(r, D - 1)));
        settle();
        chk_rd_flags("R3 R5 still empty");
    endtask

    initial begin
        #20;
        chk(empty_n == 0 && aempty_n == 0, "R1 reset read flags", int'({empty_n, aempty_n}), 0);
        chk(full_n == 1 && afull_n == 1, "R1 reset write flags", int'({full_n, afull_n}), 3);
        #31 rst_n = 1'b1;
        settle();
        chk_rd_flags("R1 idle after reset");
        chk_wr_flags("R1 idle after reset");

        // R2: wrong direction stores nothing
        @(negedge wr_clk);
        wr_en_n = 1'b0; wr_dir = 1'b1; wr_data = 18'h2AAAA;
        repeat (3) @(negedge wr_clk);
        wr_en_n = 1'b1; wr_dir = 1'b0;
        settle();
        chk(empty_n == 1'b0, "R2 wr_dir=1 ignored", int'(empty_n), 0);

        // R1 default offsets (8,8) exercised by full sweep
        sweep(1, 8, 8, 1'b0);
        sweep(2, 0, 0, 1'b1);
        sweep(3, 3, 5, 1'b1);
        sweep(4, 15, 1, 1'b1);

        // R4: output hold with enable high or direction set to write
        push(pat(9, 0)); push(pat(9, 1)); cnt = 2;
        settle();
        pop(); cnt = 1;
        chk(rd_data == pat(9, 0), "R4 first pop", int'(rd_data), int'(pat(9, 0)));
        @(negedge rd_clk);
        rd_en_n = 1'b1; rd_dir = 1'b1;
        repeat (4) @(negedge rd_clk);
        chk(rd_data == pat(9, 0), "R4 hold en high", int'(rd_data), int'(pat(9, 0)));
        rd_en_n = 1'b0; rd_dir = 1'b0;
        repeat (4) @(negedge rd_clk);
        rd_en_n = 1'b1; rd_dir = 1'b1;
        chk(rd_data == pat(9, 0), "R4 hold dir write", int'(rd_data), int'(pat(9, 0)));
        settle();
        chk_rd_flags("R4 nothing removed");
        pop(); cnt = 0;
        chk(rd_data == pat(9, 1), "R4 second pop", int'(rd_data), int'(pat(9, 1)));
        settle();
        chk_rd_flags("R5 drained");

        // streaming under back-pressure, R2 R10
        fork
            begin
                int i = 0, k = 0;
                while (i < 3 * D) begin
                    @(negedge wr_clk);
                    k++;
                    if (full_n && (k % 5 != 3)) begin
                        wr_en_n = 1'b0; wr_dir = 1'b0; wr_data = pat(7, i);
                        @(posedge wr_clk);
                        i++;
                    end else wr_en_n = 1'b1;
                end
                @(negedge wr_clk);
                wr_en_n = 1'b1;
            end
            begin
                int j = 0, k = 0;
                bit pend = 0;
                while (j < 3 * D || pend) begin
                    @(negedge rd_clk);
                    k++;
                    if (pend) begin
                        chk(rd_data == pat(7, j - 1), "R2 R10 stream order", int'(rd_data), int'(pat(7, j - 1)));
                        pend = 0;
                    end
                    if (j < 3 * D && empty_n && (k % 7 > 1)) begin
                        rd_en_n = 1'b0; rd_dir = 1'b1;
                        pend = 1; j++;
                    end else rd_en_n = 1'b1;
                end
                rd_en_n = 1'b1;
            end
        join
        cnt = 0;
        settle();
        chk_rd_flags("R10 stream end");
        chk_wr_flags("R10 stream end");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule